// File: doc/BRIEF.md
# Vectored Fixed-Priority Interrupt Controller

This block gathers twenty-four maskable interrupt request lines for an 8-bit CPU core. Each line passes through a synchroniser. A rising edge sets a sticky pending flag for that source. The pending flags are gated by per-source enable bits and by one global enable. A fixed-priority picker then chooses a single winner, and the lowest-numbered source wins.

The CPU states on `eoi_i` that it is in the last cycle of an instruction. Only in that cycle does the controller accept an interrupt. It then raises a registered request strobe together with a registered 16-bit vector address. The vector for source n is 0003h plus eight times (n minus 1). The strobe and the vector stay frozen until the CPU pulses `ack_i`. The acknowledge clears the winning flag in hardware.

Software reaches the enables and the flags through a byte-wide write/read port. The map has four enable registers, one control register and three pending-flag registers. Reset has its own non-maskable entry at vector 0000h, which sits outside this block.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `irq_req_o` is 0, `irq_vec_o` is 0, and every register (addresses 0 to 7) reads 0.
- R2: A 0-to-1 transition on `src_req_i[n-1]` sets the pending flag of source n. A line held high sets the flag only once. Pending flags read at address 5 (sources 1–8), 6 (9–16) and 7 (17–24), with the lowest source in bit 0.
- R3: No interrupt is raised unless bit 0 of address 4 (global enable) is 1 and the source's own enable bit is 1. A masked source still records its pending flag.
- R4: `irq_req_o` rises only on the clock edge that samples `eoi_i` high while a pending, enabled source exists. Without `eoi_i` it stays low.
- R5: The vector for source n is 16'h0003 + 8·(n−1): source 1 gives 0003h, source 24 gives 00BBh.
- R6: When several enabled flags are pending, the lowest-numbered source is selected.
- R7: While `irq_req_o` is high, `irq_vec_o` does not change, even when a higher-priority request arrives.
- R8: `ack_i` sampled high while `irq_req_o` is high drops `irq_req_o` on that edge and clears only the winning flag. Other flags stay set.
- R9: Writing a 0 to a bit of a pending register clears that flag. Writing a 1 leaves it unchanged.
- R10: Enable register k (address k, k = 0..3) bit b enables source 6k+b+1. Bits 7:6 are not stored and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req_i | input | 24 | Raw request lines, bit n-1 for source n |
| reg_addr_i | input | 3 | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| eoi_i | input | 1 | CPU is in the last cycle of an instruction |
| ack_i | input | 1 | CPU acknowledges the presented interrupt |
| irq_req_o | output | 1 | Registered interrupt request strobe |
| irq_vec_o | output | 16 | Registered vector address |

## Verification
A corrupted pending flag shows on the next read of its pending register. The first `eoi_i` pulse after the corruption also exposes it, as a missing strobe, an extra strobe or a wrong vector. A fault in the priority or vector arithmetic shows up one edge after the accepting `eoi_i`, as an unexpected vector. A fault in the hold logic shows as a vector that moves while the strobe is high. A failed flag clear on acknowledge makes the same source come back at the next instruction boundary. The scoreboard catches that as a surplus or out-of-order vector.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int NUM_SRC    = 24;
  localparam int PER_REG    = 6;
  localparam int NUM_EN_REG = NUM_SRC / PER_REG;
  localparam int PEND_BYTES = (NUM_SRC + 7) / 8;
  localparam int GIE_ADDR   = NUM_EN_REG;
  localparam int PEND_BASE  = NUM_EN_REG + 1;
  localparam int NUM_REGS   = PEND_BASE + PEND_BYTES;
  localparam int ADDR_W     = $clog2(NUM_REGS);
  localparam int IDX_W      = $clog2(NUM_SRC);
  localparam int VEC_W      = 16;
  localparam logic [VEC_W-1:0] VEC_BASE   = 16'h0003;
  localparam logic [VEC_W-1:0] VEC_STRIDE = 16'h0008;

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    logic [VEC_W-1:0] wide;
    wide = {{(VEC_W-IDX_W){1'b0}}, idx};
    return VEC_BASE + (wide << $clog2(VEC_STRIDE));
  endfunction
endpackage

// File: rtl/ivc_sync.sv
module ivc_sync #(
  parameter int WIDTH  = ivc_pkg::NUM_SRC,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] stage_q [STAGES+1];

  genvar s;
  generate
    for (s = 0; s <= STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= raw_i;
        else stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign rise_o = stage_q[STAGES-1] & ~stage_q[STAGES];
endmodule

// File: rtl/ivc_regs.sv
module ivc_regs
  import ivc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] hw_clr_i,
  output logic [NUM_SRC-1:0] live_o,
  output logic               gie_o
);
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] pend_q;
  logic               gie_q;
  logic [NUM_SRC-1:0] sw_clr;

  always_comb begin
    sw_clr = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (we_i && (int'(addr_i) == PEND_BASE + i / 8) && !wdata_i[i % 8])
        sw_clr[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      gie_q <= 1'b0;
    end else if (we_i) begin
      for (int k = 0; k < NUM_EN_REG; k++)
        if (int'(addr_i) == k) en_q[k*PER_REG +: PER_REG] <= wdata_i[PER_REG-1:0];
      if (int'(addr_i) == GIE_ADDR) gie_q <= wdata_i[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (set_i[i]) pend_q[i] <= 1'b1;
        else if (hw_clr_i[i] || sw_clr[i]) pend_q[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_EN_REG; k++)
      if (int'(addr_i) == k) rdata_o[PER_REG-1:0] = en_q[k*PER_REG +: PER_REG];
    if (int'(addr_i) == GIE_ADDR) rdata_o[0] = gie_q;
    for (int j = 0; j < PEND_BYTES; j++)
      if (int'(addr_i) == PEND_BASE + j)
        for (int b = 0; b < 8; b++)
          if (j*8 + b < NUM_SRC) rdata_o[b] = pend_q[j*8 + b];
  end

  assign live_o = pend_q & en_q & {NUM_SRC{gie_q}};
  assign gie_o  = gie_q;
endmodule

// File: rtl/ivc_prio.sv
module ivc_prio
  import ivc_pkg::*;
(
  input  logic [NUM_SRC-1:0] live_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_SRC-1; i >= 0; i--)
      if (live_i[i]) idx_o = IDX_W'(i);
  end
  assign any_o = |live_i;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic               reg_we_i,
  input  logic [7:0]         reg_wdata_i,
  output logic [7:0]         reg_rdata_o,
  input  logic               eoi_i,
  input  logic               ack_i,
  output logic               irq_req_o,
  output logic [VEC_W-1:0]   irq_vec_o
);
  logic [NUM_SRC-1:0] rise_w;
  logic [NUM_SRC-1:0] live_w;
  logic [NUM_SRC-1:0] hw_clr_w;
  logic               any_w;
  logic [IDX_W-1:0]   win_w;
  logic               gie_w;
  logic               accept_w;
  logic               ack_w;
  logic [IDX_W-1:0]   sel_q;
  logic               req_q;
  logic [VEC_W-1:0]   vec_q;

  ivc_sync #(.WIDTH(NUM_SRC), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(src_req_i), .rise_o(rise_w)
  );

  ivc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(reg_addr_i), .we_i(reg_we_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .set_i(rise_w),
    .hw_clr_i(hw_clr_w), .live_o(live_w), .gie_o(gie_w)
  );

  ivc_prio u_prio (.live_i(live_w), .any_o(any_w), .idx_o(win_w));

  assign accept_w = !req_q && eoi_i && any_w;
  assign ack_w    = req_q && ack_i;

  always_comb begin
    hw_clr_w = '0;
    if (ack_w) hw_clr_w[sel_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      vec_q <= '0;
      sel_q <= '0;
    end else if (ack_w) begin
      req_q <= 1'b0;
    end else if (accept_w) begin
      req_q <= 1'b1;
      sel_q <= win_w;
      vec_q <= vec_of(win_w);
    end
  end

  assign irq_req_o = req_q;
  assign irq_vec_o = vec_q;
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        eoi_i,
  input logic        ack_i,
  input logic        gie_w,
  input logic        irq_req_o,
  input logic [15:0] irq_vec_o
);
  // R4
  accept_at_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req_o) |-> $past(eoi_i));
  // R3
  gated_by_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req_o) |-> $past(gie_w));
  // R7
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_o && $past(irq_req_o)) |-> $stable(irq_vec_o));
  // R8
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_o && ack_i) |=> !irq_req_o);
  // R5
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (irq_vec_o[2:0] == 3'd3 && irq_vec_o <= 16'h00BB));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .eoi_i(eoi_i), .ack_i(ack_i),
  .gie_w(gie_w), .irq_req_o(irq_req_o), .irq_vec_o(irq_vec_o)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] src_req = '0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        eoi = 1'b0;
  logic        ack = 1'b0;
  logic        irq_req;
  logic [15:0] irq_vec;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] exp_q[$];
  logic prev_req = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .src_req_i(src_req), .reg_addr_i(addr),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .eoi_i(eoi), .ack_i(ack), .irq_req_o(irq_req), .irq_vec_o(irq_vec)
  );

  function automatic logic [15:0] exp_vec(input int n);
    return 16'(3 + (n - 1) * 8);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = 3'(a); wdata = 8'(d); we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string req);
    @(negedge clk);
    addr = 3'(a);
    #1;
    chk(rdata == 8'(exp), req, rdata, exp);
  endtask

  task automatic pulse_src(input int n);
    @(negedge clk);
    src_req[n-1] = 1'b1;
    @(negedge clk);
    src_req[n-1] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // driver: pushes the expected vector when an acceptance is due
  task automatic eoi_pulse(input bit expect_take, input int n);
    @(negedge clk);
    if (expect_take) exp_q.push_back(exp_vec(n));
    eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
  endtask

  task automatic ack_pulse;
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    #1;
    chk(irq_req == 1'b0, "R8 req drops on ack", irq_req, 0);
  endtask

  // monitor: compares each new strobe against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && irq_req && !prev_req) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected strobe", irq_vec, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(irq_vec == e, "R5/R6 vector", irq_vec, e);
      end
    end
    prev_req <= irq_req;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(irq_req == 1'b0 && irq_vec == 16'h0, "R1 outputs in reset", irq_vec, 0);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) rd_chk(a, 0, "R1 register reset");

    // R10: upper bits not stored
    wr(0, 8'hFF);
    rd_chk(0, 8'h3F, "R10 enable width");

    // R2/R3: masked source still pends, no strobe
    pulse_src(3);
    rd_chk(5, 8'h04, "R2 pending set");
    eoi_pulse(1'b0, 0);
    #1 chk(irq_req == 1'b0, "R3 gie off blocks", irq_req, 0);

    // R4: enable global, wait without eoi
    wr(4, 1);
    repeat (5) @(negedge clk);
    #1 chk(irq_req == 1'b0, "R4 no strobe without eoi", irq_req, 0);
    eoi_pulse(1'b1, 3);
    #1 chk(irq_req == 1'b1, "R4 strobe after eoi", irq_req, 1);
    ack_pulse();
    rd_chk(5, 8'h00, "R8 flag cleared by ack");

    // R6/R7: priority and hold
    wr(1, 8'h3F); wr(2, 8'h3F); wr(3, 8'h3F);
    pulse_src(20);
    pulse_src(7);
    eoi_pulse(1'b1, 7);
    pulse_src(1);
    #1 chk(irq_vec == exp_vec(7), "R7 vector held", irq_vec, exp_vec(7));
    eoi_pulse(1'b0, 0);
    #1 chk(irq_vec == exp_vec(7) && irq_req, "R7 eoi while busy", irq_vec, exp_vec(7));
    ack_pulse();
    rd_chk(5, 8'h01, "R8 others kept byte0");
    rd_chk(7, 8'h08, "R8 others kept byte2");
    eoi_pulse(1'b1, 1);
    ack_pulse();
    eoi_pulse(1'b1, 20);
    ack_pulse();

    // R5: highest source
    pulse_src(24);
    eoi_pulse(1'b1, 24);
    #1 chk(irq_vec == 16'h00BB, "R5 source 24 vector", irq_vec, 16'h00BB);
    ack_pulse();

    // R10 mapping: only enable reg 2 bit 2 -> source 15
    wr(0, 0); wr(1, 0); wr(3, 0); wr(2, 8'h04);
    pulse_src(14); pulse_src(15); pulse_src(16);
    eoi_pulse(1'b1, 15);
    #1 chk(irq_vec == exp_vec(15), "R10 mapping", irq_vec, exp_vec(15));
    ack_pulse();
    rd_chk(6, 8'hA0, "R10 others pending");
    eoi_pulse(1'b0, 0);
    #1 chk(irq_req == 1'b0, "R3 disabled sources idle", irq_req, 0);

    // R9: write 0 clears, write 1 keeps
    wr(6, 8'h7F);
    rd_chk(6, 8'h20, "R9 selective clear");
    wr(6, 8'h00);
    rd_chk(6, 8'h00, "R9 full clear");

    // R2: held-high line sets the flag only once
    @(negedge clk);
    src_req[1] = 1'b1;
    repeat (5) @(negedge clk);
    rd_chk(5, 8'h02, "R2 held line pends");
    wr(5, 8'h00);
    repeat (5) @(negedge clk);
    rd_chk(5, 8'h00, "R2 no re-set while held");
    src_req[1] = 1'b0;

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R4 missing strobe", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule